// File: doc/BRIEF.md
# SECDED Hamming Codec (8-bit data, 13-bit codeword)

This block protects one byte with a single-error-correcting, double-error-detecting Hamming code. The encoder path turns 8 data bits into a 13-bit codeword. Four even-parity check bits sit at the power-of-two positions of a 12-bit Hamming word. An overall parity bit is prepended on the left, so that all 13 bits together have even parity.

The decoder path takes a received 13-bit word and recomputes the check bits to form a 4-bit syndrome. The syndrome value is the position of the failing bit. The decoder combines the syndrome with the overall parity to tell four cases apart: no error, a correctable single error, a double error, and an uncorrectable pattern. For a single error it flips the indicated bit and returns the repaired data. Both paths are combinational. A parameter selects whether the results leave through a register stage qualified by a valid strobe, or go straight to the outputs.

Top module: `secded_codec`

## Requirements
- R1: Positions are numbered 0..12 from the left. Position k is codeword bit 12-k, so the overall parity bit (position 0) is bit 12. Check bits sit at positions 1, 2, 4 and 8. Data bits d7..d0 fill positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order.
- R2: Each check bit gives even parity over its group. The group of position 1 is 1,3,5,7,9,11. The group of position 2 is 2,3,6,7,10,11. The group of position 4 is 4,5,6,7,12. The group of position 8 is 8,9,10,11,12.
- R3: The encoder sets the overall parity bit so that all 13 codeword bits have even parity.
- R4: For an unmodified codeword, the decoder reports syndrome 0, clears both error flags and returns the original data.
- R5: With exactly one bit inverted at position 1..12, the syndrome equals that position, the single flag is set, the double flag is clear and the data is fully repaired.
- R6: With only the overall parity bit inverted, the syndrome is 0, the single flag is set and the data is unchanged.
- R7: With two bits inverted, the double flag is set, the single flag is clear, the syndrome is the XOR of the two nonzero positions, and the data is the uncorrected data field of the received word.
- R8: If the overall parity is odd and the syndrome is 13, 14 or 15, the pattern is uncorrectable. The double flag is set, the single flag is clear and the data is not modified.
- R9: With OUT_REG=1, results captured while in_valid is high appear one clock later with out_valid high. While in_valid is low, out_valid falls one clock later and all result outputs hold their last values. Reset clears every output.
- R10: With OUT_REG=0, every output follows its inputs in the same cycle, and out_valid equals in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies enc_data and rx_code |
| enc_data | input | 8 | Byte to encode |
| rx_code | input | 13 | Received codeword to decode |
| out_valid | output | 1 | Results valid |
| enc_code | output | 13 | Encoded codeword |
| dec_data | output | 8 | Decoded (corrected where possible) byte |
| dec_syndrome | output | 4 | Position of the failing bit, 0 if none among 1..12 |
| dec_single | output | 1 | Single error seen and corrected |
| dec_double | output | 1 | Double error or uncorrectable pattern seen |

## Verification
The bench builds two instances side by side. One has OUT_REG=1, so the one-cycle latency, the valid strobe and the hold of results through idle cycles can be observed. The other has OUT_REG=0, which exposes the same decode results in the cycle they are driven. Both receive every data byte, single flips at all thirteen positions, pairs of flips, and triple flips chosen so that the syndrome lands on 13, 14 and 15.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 8;
  localparam int HAM_W  = 12;
  localparam int CODE_W = HAM_W + 1;
  localparam int SYN_W  = 4;

  // position 0 is the leftmost bit (MSB) of the codeword
  function automatic int pos2idx(input int p);
    return CODE_W - 1 - p;
  endfunction

  function automatic bit is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // position carrying the k-th data bit counted from the MSB
  function automatic int data_pos(input int k);
    int n;
    int res;
    n   = 0;
    res = 0;
    for (int p = 1; p <= HAM_W; p++) begin
      if (!is_pow2(p)) begin
        if (n == k) res = p;
        n++;
      end
    end
    return res;
  endfunction

  function automatic logic [DATA_W-1:0] extract_data(input logic [CODE_W-1:0] cw);
    logic [DATA_W-1:0] d;
    for (int k = 0; k < DATA_W; k++) d[DATA_W-1-k] = cw[pos2idx(data_pos(k))];
    return d;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);
  logic [HAM_W-1:0] raw_w;
  logic [HAM_W-1:0] ham_w;

  // scatter data into its positions
  always_comb begin
    raw_w = '0;
    for (int k = 0; k < DATA_W; k++) raw_w[pos2idx(data_pos(k))] = data_i[DATA_W-1-k];
  end

  // fill every power-of-two position with even parity over its group
  always_comb begin
    ham_w = raw_w;
    for (int c = 0; c < SYN_W; c++) begin : g_chk
      logic par;
      par = 1'b0;
      for (int p = 1; p <= HAM_W; p++) begin
        if (((p & (1 << c)) != 0) && (p != (1 << c))) par = par ^ raw_w[pos2idx(p)];
      end
      if ((1 << c) <= HAM_W) ham_w[pos2idx(1 << c)] = par;
    end
  end

  assign code_o = {^ham_w, ham_w};
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [DATA_W-1:0] data_o,
  output logic [SYN_W-1:0]  syn_o,
  output logic              single_o,
  output logic              double_o
);
  logic [SYN_W-1:0]  syn_w;
  logic              odd_w;
  logic [CODE_W-1:0] fixed_w;

  // syndrome: XOR of the positions of all set bits among 1..HAM_W
  always_comb begin
    syn_w = '0;
    for (int p = 1; p <= HAM_W; p++) begin
      if (code_i[pos2idx(p)]) syn_w = syn_w ^ SYN_W'(p);
    end
  end

  assign odd_w = ^code_i;

  // outcome decision and single-bit repair
  always_comb begin
    single_o = 1'b0;
    double_o = 1'b0;
    fixed_w  = code_i;
    if (odd_w) begin
      if (int'(syn_w) > HAM_W) begin
        double_o = 1'b1;
      end else begin
        single_o = 1'b1;
        for (int p = 0; p <= HAM_W; p++) begin
          if (int'(syn_w) == p) fixed_w[pos2idx(p)] = ~code_i[pos2idx(p)];
        end
      end
    end else if (syn_w != '0) begin
      double_o = 1'b1;
    end
  end

  assign syn_o  = syn_w;
  assign data_o = extract_data(fixed_w);
endmodule

// File: rtl/secded_outstage.sv
module secded_outstage #(
  parameter bit OUT_REG = 1'b1,
  parameter int W       = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] d_i,
  output logic         vld_o,
  output logic [W-1:0] q_o
);
  if (OUT_REG) begin : g_reg
    logic [W-1:0] q_r, q_nxt;
    logic         v_r, v_nxt;

    always_comb begin
      q_nxt = vld_i ? d_i : q_r;
      v_nxt = vld_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_r <= '0;
        v_r <= 1'b0;
      end else begin
        q_r <= q_nxt;
        v_r <= v_nxt;
      end
    end

    assign vld_o = v_r;
    assign q_o   = q_r;

    p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vld_i |=> vld_o);
    p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |=> !vld_o);
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |=> $stable(q_o));
  end else begin : g_pass
    assign vld_o = vld_i;
    assign q_o   = d_i;
  end
endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] enc_data,
  input  logic [CODE_W-1:0] rx_code,
  output logic              out_valid,
  output logic [CODE_W-1:0] enc_code,
  output logic [DATA_W-1:0] dec_data,
  output logic [SYN_W-1:0]  dec_syndrome,
  output logic              dec_single,
  output logic              dec_double
);
  localparam int PW = CODE_W + DATA_W + SYN_W + 2;

  logic [CODE_W-1:0] enc_code_c;
  logic [DATA_W-1:0] dec_data_c;
  logic [SYN_W-1:0]  dec_syn_c;
  logic              dec_single_c, dec_double_c;
  logic [PW-1:0]     pay_c, pay_q;

  secded_enc u_enc (.data_i(enc_data), .code_o(enc_code_c));

  secded_dec u_dec (
    .code_i(rx_code), .data_o(dec_data_c), .syn_o(dec_syn_c),
    .single_o(dec_single_c), .double_o(dec_double_c)
  );

  assign pay_c = {enc_code_c, dec_data_c, dec_syn_c, dec_single_c, dec_double_c};

  secded_outstage #(.OUT_REG(OUT_REG), .W(PW)) u_out (
    .clk(clk), .rst_n(rst_n), .vld_i(in_valid), .d_i(pay_c),
    .vld_o(out_valid), .q_o(pay_q)
  );

  assign {enc_code, dec_data, dec_syndrome, dec_single, dec_double} = pay_q;

  // encoder output always has even weight over all 13 bits
  p_enc_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (^enc_code_c) == 1'b0);
  // even received weight never yields a correction
  p_even_no_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ((^rx_code) == 1'b0)) |-> !dec_single_c);
  // P0-only error leaves the data field untouched
  p_p0_keeps_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_single_c && (dec_syn_c == '0)) |-> (dec_data_c == extract_data(rx_code)));
  // detected-but-uncorrected words pass data through raw
  p_double_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_double_c) |-> (dec_data_c == extract_data(rx_code)));
  // uncorrectable syndromes with odd weight are never marked single
  p_uncorr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ((^rx_code) == 1'b1) && (dec_syn_c > 4'd12)) |-> (dec_double_c && !dec_single_c));
endmodule

// File: tb/secded_codec_bench.sv
module secded_codec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  enc_data = '0;
  logic [12:0] rx_code = '0;

  logic        ov_r, sg_r, db_r, ov_c, sg_c, db_c;
  logic [12:0] ec_r, ec_c;
  logic [7:0]  dd_r, dd_c;
  logic [3:0]  sy_r, sy_c;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct packed {
    logic [12:0] enc;
    logic [7:0]  data;
    logic [3:0]  syn;
    logic        single;
    logic        dbl;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  exp_t  last_exp;
  bit    have_last = 0;

  always #2 clk = ~clk;

  secded_codec #(.OUT_REG(1'b1)) u_secded_codec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .enc_data(enc_data), .rx_code(rx_code),
    .out_valid(ov_r), .enc_code(ec_r), .dec_data(dd_r), .dec_syndrome(sy_r),
    .dec_single(sg_r), .dec_double(db_r));

  secded_codec #(.OUT_REG(1'b0)) u_secded_codec_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .enc_data(enc_data), .rx_code(rx_code),
    .out_valid(ov_c), .enc_code(ec_c), .dec_data(dd_c), .dec_syndrome(sy_c),
    .dec_single(sg_c), .dec_double(db_c));

  function automatic int dpos(input int k);
    int t[8] = '{3, 5, 6, 7, 9, 10, 11, 12};
    return t[k];
  endfunction

  // R1, R2, R3: reference encoder from the explicit group lists
  function automatic logic [12:0] ref_enc(input logic [7:0] d);
    logic b[13];
    logic [12:0] cw;
    for (int i = 0; i < 13; i++) b[i] = 1'b0;
    for (int k = 0; k < 8; k++) b[dpos(k)] = d[7-k];
    b[1] = b[3] ^ b[5] ^ b[7] ^ b[9] ^ b[11];
    b[2] = b[3] ^ b[6] ^ b[7] ^ b[10] ^ b[11];
    b[4] = b[5] ^ b[6] ^ b[7] ^ b[12];
    b[8] = b[9] ^ b[10] ^ b[11] ^ b[12];
    b[0] = 1'b0;
    for (int i = 1; i < 13; i++) b[0] = b[0] ^ b[i];
    for (int i = 0; i < 13; i++) cw[12-i] = b[i];
    return cw;
  endfunction

  function automatic logic [7:0] ref_extract(input logic [12:0] cw);
    logic [7:0] d;
    for (int k = 0; k < 8; k++) d[7-k] = cw[12-dpos(k)];
    return d;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_item(input string tag, input exp_t e, input logic [12:0] ec,
                          input logic [7:0] dd, input logic [3:0] sy, input logic sg, input logic db);
    check(ec == e.enc, tag, "enc_code", 16'(ec), 16'(e.enc));
    check(dd == e.data, tag, "dec_data", 16'(dd), 16'(e.data));
    check(sy == e.syn, tag, "syndrome", 16'(sy), 16'(e.syn));
    check(sg == e.single, tag, "single", 16'(sg), 16'(e.single));
    check(db == e.dbl, tag, "double", 16'(db), 16'(e.dbl));
  endtask

  // driver: flip mask bit k inverts position k (codeword bit 12-k)
  task automatic send(input logic [7:0] d, input logic [12:0] pmask, input string tag);
    exp_t e;
    logic [12:0] cw, fl;
    int nf;
    logic [3:0] s;
    @(negedge clk);
    cw = ref_enc(d);
    nf = 0;
    s  = '0;
    for (int k = 0; k < 13; k++) begin
      fl[12-k] = pmask[k];
      if (pmask[k]) begin
        nf++;
        if (k > 0) s = s ^ 4'(k);
      end
    end
    rx_code  = cw ^ fl;
    enc_data = d ^ 8'h3C;
    in_valid = 1'b1;
    e.enc    = ref_enc(d ^ 8'h3C);
    e.syn    = s;
    e.single = (nf == 1);
    e.dbl    = (nf >= 2);
    e.data   = (nf <= 1) ? d : ref_extract(cw ^ fl);
    expq.push_back(e);
    tagq.push_back(tag);
    #1;
    // R10: pass-through instance follows in the same cycle
    check(ov_c == 1'b1, "R10", "comb out_valid", 16'(ov_c), 16'd1);
    cmp_item("R10", e, ec_c, dd_c, sy_c, sg_c, db_c);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      enc_data = 8'hFF;
      rx_code  = 13'h1ABC;
    end
  endtask

  // monitor / scoreboard for the registered instance
  always @(negedge clk) begin
    if (rst_n) begin
      if (ov_r) begin
        if (expq.size() == 0) begin
          check(1'b0, "R9", "unexpected out_valid", 16'd1, 16'd0);
        end else begin
          exp_t e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          cmp_item(t, e, ec_r, dd_r, sy_r, sg_r, db_r);
          last_exp  = e;
          have_last = 1;
        end
      end else if (have_last) begin
        // R9: outputs hold while idle
        cmp_item("R9", last_exp, ec_r, dd_r, sy_r, sg_r, db_r);
      end
    end
  end

  bit done = 0;
  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    // R9: reset clears outputs
    check(ov_r == 1'b0, "R9", "reset out_valid", 16'(ov_r), 16'd0);
    check(dd_r == 8'h00 && ec_r == 13'h0, "R9", "reset data", 16'(dd_r), 16'd0);
    check(!sg_r && !db_r && sy_r == 4'h0, "R9", "reset flags", 16'({sg_r, db_r, sy_r}), 16'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R2 R3 R4: every byte, clean
    for (int d = 0; d < 256; d++) send(8'(d), 13'h0, "R4");
    idle(3);
    // R5: every single position 1..12 on several bytes
    for (int d = 0; d < 256; d += 37)
      for (int k = 1; k < 13; k++) send(8'(d), 13'(1 << k), "R5");
    // R6: overall parity bit only
    for (int d = 0; d < 256; d += 51) send(8'(d), 13'h1, "R6");
    idle(2);
    // R7: all pairs of positions
    for (int a = 0; a < 13; a++)
      for (int b = a + 1; b < 13; b++) send(8'hA5 ^ 8'(a * 7 + b), 13'((1 << a) | (1 << b)), "R7");
    // R8: triple flips with odd weight and syndrome 13..15
    send(8'h5A, 13'((1 << 0) | (1 << 3) | (1 << 12)), "R8");
    send(8'hC3, 13'((1 << 0) | (1 << 5) | (1 << 10)), "R8");
    send(8'h0F, 13'((1 << 0) | (1 << 6) | (1 << 9)), "R8");
    send(8'hF0, 13'((1 << 0) | (1 << 7) | (1 << 8)), "R8");
    send(8'h81, 13'((1 << 0) | (1 << 1) | (1 << 12)), "R8");
    send(8'h7E, 13'((1 << 0) | (1 << 2) | (1 << 12)), "R8");
    idle(4);
    check(expq.size() == 0, "R9", "queue drained", 16'(expq.size()), 16'd0);
    check(ov_r == 1'b0, "R9", "idle out_valid", 16'(ov_r), 16'd0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule